// File: doc/BRIEF.md
# Atomic Header FIFO Loader

This block lets software place a short header of one to four bytes into a transmit byte FIFO as a single, indivisible operation, with the outcome tied to the state of an external chip-select line. Software presents a header write with a size code and up to 32 bits of data. The block then decides in one cycle whether to take the write. An accepted header is streamed into the FIFO one byte per handshake. A rejected header pushes no byte at all.

The chip-select input is asynchronous, and it is brought through a synchronizer before any decision uses it. A four-bit control word holds four fields: an enable, a sticky committed flag, a sticky ignored flag, and a gating bit that picks the policy. In the gated (blocking) policy, software must set the enable, and writes made while chip select is active are refused. In the ungated (non-blocking) policy, any header write sets the enable by itself. The first write made while chip select is active is still accepted when no header was loaded beforehand. Once a header is committed, later writes are refused under both policies.

The FIFO storage and the serial engine sit outside this block. The FIFO reports its free space on `fifo_free` and takes bytes over a valid/ready stream. While `push_valid` is high and `push_ready` is low, the block keeps `push_valid` high and `push_data` unchanged. A byte is transferred on each clock edge where both are high.

Top module: `atomic_hdr_loader`

## Requirements
- R1: After reset, `ctl_rdata` reads 0 and `push_valid` is low.
- R2: `cs_n` passes through two synchronizing flops. After `cs_n` falls with the enable set, the committed flag is still 0 after the second clock edge and reads 1 after the third.
- R3: `hdr_size` code k (0..3) selects k+1 header bytes taken from `hdr_data[8*(k+1)-1:0]`. An accepted header is pushed least-significant byte first, one byte per handshake, and no other bytes are pushed.
- R4: While `push_valid` is high and `push_ready` is low, `push_valid` stays high and `push_data` holds its value on the next cycle.
- R5: A header write is refused if `fifo_free` is below its byte count, or if a previous header is still being pushed. A refused write sets the ignored flag and pushes no byte.
- R6: The committed flag sets one cycle after the enable is seen set while the synchronized chip select is active.
- R7: In a control write, a 0 in the committed or ignored position clears that flag. A 1 in either position leaves the flag unchanged. A set condition in the same cycle wins over the clear.
- R8: With gating set, a header write is accepted only when the enable is set, chip select is inactive and the committed flag is clear. Otherwise the write is refused and sets the ignored flag.
- R9: With gating clear, every header write sets the enable, whether or not the write is accepted.
- R10: With gating clear and nothing loaded before chip select became active, the first header write made while it is active is accepted and sets the committed flag. When a header was loaded while chip select was inactive, writes made after it became active are refused.
- R11: Under either policy, a header write made while the committed flag is set is refused and sets the ignored flag.
- R12: The ignored flag stays set until software clears it as in R7.
- R13: A control write loads the enable and gating fields directly. The control word layout is bit 0 enable, bit 1 ignored, bit 2 committed, bit 3 gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | External chip select, active low, asynchronous |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word write data |
| ctl_rdata | output | 4 | Current control word |
| hdr_wr | input | 1 | Header write strobe |
| hdr_size | input | 2 | Header size code, byte count minus one |
| hdr_data | input | 32 | Header bytes, right-justified |
| fifo_free | input | 6 | Free byte slots in the downstream FIFO |
| push_valid | output | 1 | Header byte available |
| push_ready | input | 1 | FIFO takes the byte this cycle |
| push_data | output | 8 | Header byte |

## Verification
Some rules hold on every cycle, and the embedded assertions check those:
- the commit that follows an active chip select while the enable is set;
- stickiness of the ignored flag;
- refusal of writes after a commit;
- automatic enable under the ungated policy;
- the blocking of gated writes while chip select is active;
- the stream hold rule under back-pressure.

Other behaviour needs a whole scenario before it can be seen, so only the bench shows it:
- that accepted headers arrive complete and in byte order;
- that refused headers leave no bytes behind;
- the exact synchronizer latency;
- the ordering in which the ungated policy accepts a write before or after chip select falls.

// File: rtl/ahl_pkg.sv
package ahl_pkg;
  // Control word, bit 3 down to bit 0
  typedef struct packed {
    logic gate;  // 1: blocking policy
    logic cmt;   // header committed
    logic ign;   // header write refused
    logic en;    // header feature enabled
  } hdr_ctl_t;
endpackage

// File: rtl/ahl_cs_sync.sv
module ahl_cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_async,
  output logic cs_active
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], cs_n_async};
  end

  assign cs_active = ~chain[STAGES-1];
endmodule

// File: rtl/ahl_ctrl.sv
module ahl_ctrl
  import ahl_pkg::*;
#(
  parameter int SZW    = 2,
  parameter int CNT_W  = 3,
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  hdr_ctl_t          ctl_wdata,
  input  logic              hdr_wr,
  input  logic [SZW-1:0]    hdr_size,
  input  logic              cs_low,
  input  logic [FREE_W-1:0] fifo_free,
  input  logic              pusher_busy,
  output hdr_ctl_t          ctl,
  output logic              accept,
  output logic [CNT_W-1:0]  acc_bytes
);
  hdr_ctl_t nxt;
  logic     room;

  always_comb begin
    acc_bytes = CNT_W'(hdr_size) + CNT_W'(1);
    room      = ({1'b0, fifo_free} >= (FREE_W+1)'(acc_bytes)) && !pusher_busy;
    if (ctl.gate)
      accept = hdr_wr && ctl.en && !cs_low && !ctl.cmt && room;
    else
      accept = hdr_wr && !ctl.cmt && !(cs_low && ctl.en) && room;
  end

  always_comb begin
    nxt = ctl;
    if (ctl_wr) begin
      nxt.en   = ctl_wdata.en;
      nxt.gate = ctl_wdata.gate;
      if (!ctl_wdata.ign) nxt.ign = 1'b0;
      if (!ctl_wdata.cmt) nxt.cmt = 1'b0;
    end
    if (hdr_wr && !ctl.gate)             nxt.en  = 1'b1;
    if (hdr_wr && !accept)               nxt.ign = 1'b1;
    if (cs_low && (ctl.en || accept))    nxt.cmt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= nxt;
  end

  // R6: commit follows enable with chip select active
  a_r6_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.en && cs_low |=> ctl.cmt);
  // R12: ignored flag sticky unless cleared by software
  a_r12_ign_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ign && !(ctl_wr && !ctl_wdata.ign) |=> ctl.ign);
  // R11: writes after commit are refused
  a_r11_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr && ctl.cmt |=> ctl.ign);
  // R9: ungated writes raise the enable
  a_r9_auto_enable: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr && !ctl.gate |=> ctl.en);
endmodule

// File: rtl/ahl_pusher.sv
module ahl_pusher #(
  parameter int HDR_W = 32,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_bytes,
  input  logic [HDR_W-1:0] load_data,
  output logic             push_valid,
  input  logic             push_ready,
  output logic [7:0]       push_data,
  output logic             busy
);
  localparam int BYTES = HDR_W / 8;

  logic [HDR_W-1:0] sreg;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= load_data;
      left <= load_bytes;
    end else if (push_valid && push_ready) begin
      sreg <= sreg >> 8;
      left <= left - CNT_W'(1);
    end
  end

  assign push_valid = (left != '0);
  assign push_data  = sreg[7:0];
  assign busy       = push_valid;

  // R4: held under back-pressure
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_data));
  // R5: a new header never overlays one in flight
  a_r5_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  // R3: never more bytes than one header holds
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left <= CNT_W'(BYTES));
endmodule

// File: rtl/atomic_hdr_loader.sv
module atomic_hdr_loader
  import ahl_pkg::*;
#(
  parameter int HDR_W       = 32,
  parameter int FREE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          ctl_wr,
  input  logic [3:0]                    ctl_wdata,
  output logic [3:0]                    ctl_rdata,
  input  logic                          hdr_wr,
  input  logic [$clog2(HDR_W/8)-1:0]    hdr_size,
  input  logic [HDR_W-1:0]              hdr_data,
  input  logic [FREE_W-1:0]             fifo_free,
  output logic                          push_valid,
  input  logic                          push_ready,
  output logic [7:0]                    push_data
);
  localparam int BYTES = HDR_W / 8;
  localparam int SZW   = $clog2(BYTES);
  localparam int CNT_W = $clog2(BYTES + 1);

  logic             cs_low;
  hdr_ctl_t         ctl;
  logic             accept;
  logic [CNT_W-1:0] acc_bytes;
  logic             busy;

  ahl_cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_async(cs_n), .cs_active(cs_low)
  );

  ahl_ctrl #(.SZW(SZW), .CNT_W(CNT_W), .FREE_W(FREE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(hdr_ctl_t'(ctl_wdata)),
    .hdr_wr(hdr_wr), .hdr_size(hdr_size),
    .cs_low(cs_low), .fifo_free(fifo_free), .pusher_busy(busy),
    .ctl(ctl), .accept(accept), .acc_bytes(acc_bytes)
  );

  ahl_pusher #(.HDR_W(HDR_W), .CNT_W(CNT_W)) u_push (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_bytes(acc_bytes), .load_data(hdr_data),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .busy(busy)
  );

  assign ctl_rdata = ctl;

  // R8: gated writes with chip select active push nothing
  a_r8_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_wr && ctl.gate && cs_low && !push_valid |=> !push_valid);
endmodule

// File: tb/sim_atomic_hdr_loader.sv
module sim_atomic_hdr_loader;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cs_n = 1;
  logic        ctl_wr = 0;
  logic [3:0]  ctl_wdata = 0;
  logic [3:0]  ctl_rdata;
  logic        hdr_wr = 0;
  logic [1:0]  hdr_size = 0;
  logic [31:0] hdr_data = 0;
  logic [5:0]  fifo_free = 6'd32;
  logic        push_valid;
  logic        push_ready = 0;
  logic [7:0]  push_data;

  int checks = 0, errors = 0, cycles = 0;
  bit m_en, m_ign, m_cmt, m_gate, m_cslow;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  atomic_hdr_loader u0 (.*);

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog act=%0d exp=<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic settle(int n);
    repeat (n) tick();
    if (m_en && m_cslow) m_cmt = 1;
  endtask

  task automatic check_ctl(string tag);
    chk(tag, {28'd0, ctl_rdata}, {28'd0, m_gate, m_cmt, m_ign, m_en});
  endtask

  function automatic bit exp_accept(int n, int free, bit busy);
    bit room = (free >= n) && !busy;
    if (m_gate) return m_en && !m_cslow && !m_cmt && room;
    return !m_cmt && !(m_cslow && m_en) && room;
  endfunction

  task automatic ctl_write(logic [3:0] v);
    bit en_old = m_en;
    ctl_wr = 1; ctl_wdata = v; tick(); ctl_wr = 0;
    m_en = v[0]; m_gate = v[3];
    if (!v[1]) m_ign = 0;
    m_cmt = (v[2] ? m_cmt : 1'b0) | (en_old & m_cslow);
    settle(2);
    check_ctl("R13/R7 control write");
  endtask

  task automatic set_cs(bit low);
    cs_n = !low; m_cslow = low;
    settle(4);
    check_ctl("R6 chip select change");
  endtask

  // model one header write strobe (pusher assumed idle unless busy given)
  task automatic model_hdr(int k, logic [31:0] d, int free, bit busy);
    bit en_old = m_en;
    bit acc = exp_accept(k + 1, free, busy);
    if (!acc) m_ign = 1;
    if (!m_gate) m_en = 1;
    m_cmt = m_cmt | (en_old & m_cslow) | (acc & m_cslow);
    if (acc) for (int i = 0; i <= k; i++) exp_q.push_back(d[8*i +: 8]);
  endtask

  task automatic drain();
    bit stalled = 0;
    logic [7:0] prev = 0;
    for (int i = 0; i < 60; i++) begin
      push_ready = ($urandom % 4) != 0;
      #1;
      if (stalled) begin
        chk("R4 hold valid", {31'd0, push_valid}, 32'd1);
        chk("R4 hold data", {24'd0, push_data}, {24'd0, prev});
      end
      if (push_valid && push_ready) begin
        if (exp_q.size() == 0) chk("R3 unexpected byte", {24'd0, push_data}, 32'hFFFF_FFFF);
        else chk("R3 byte order", {24'd0, push_data}, {24'd0, exp_q.pop_front()});
      end
      stalled = push_valid && !push_ready;
      prev = push_data;
      tick();
      if (!push_valid && exp_q.size() == 0 && i > 2) break;
    end
    push_ready = 0;
    chk("R5 no bytes left over", exp_q.size(), 0);
    chk("R5 stream idle", {31'd0, push_valid}, 32'd0);
  endtask

  task automatic hdr_write(int k, logic [31:0] d, int free);
    hdr_wr = 1; hdr_size = 2'(k); hdr_data = d; fifo_free = 6'(free);
    tick(); hdr_wr = 0;
    model_hdr(k, d, free, 0);
    drain();
    settle(1);
    check_ctl("R8/R10/R11 flags after header");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset ctl", {28'd0, ctl_rdata}, 32'd0);
    chk("R1 reset valid", {31'd0, push_valid}, 32'd0);

    // R3: ungated, CS inactive, 4-byte header in order
    hdr_write(3, 32'hA1B2C3D4, 10);
    // R11: clear flags, commit with CS low, later write refused
    set_cs(1);
    hdr_write(1, 32'h0000_5566, 10);
    set_cs(0);
    ctl_write(4'b0000);
    // R10: nothing loaded, first write while low accepted, then commit
    set_cs(1);
    hdr_write(0, 32'h0000_0077, 10);
    chk("R10 commit after first low write", {31'd0, ctl_rdata[2]}, 32'd1);
    hdr_write(2, 32'h0033_2211, 10);
    chk("R11 ignored after commit", {31'd0, ctl_rdata[1]}, 32'd1);
    // R7: clear while CS low and enabled: set wins
    ctl_write(4'b0001);
    chk("R7 set beats clear", {31'd0, ctl_rdata[2]}, 32'd1);
    set_cs(0);
    ctl_write(4'b1000);
    // R8: gated, enable clear -> refused
    hdr_write(1, 32'h0000_ABCD, 10);
    chk("R8 gated disabled refused", {31'd0, ctl_rdata[1]}, 32'd1);
    ctl_write(4'b1001);
    hdr_write(1, 32'h0000_ABCD, 10);
    // R5: lack of room
    ctl_write(4'b1001);
    hdr_write(2, 32'h00EE_DDCC, 2);
    chk("R5 room refused", {31'd0, ctl_rdata[1]}, 32'd1);
    ctl_write(4'b1001);
    // R5: busy pusher
    hdr_wr = 1; hdr_size = 3; hdr_data = 32'h1122_3344; fifo_free = 20; tick();
    model_hdr(3, 32'h1122_3344, 20, 0);
    hdr_size = 0; hdr_data = 32'h99; tick(); hdr_wr = 0;
    model_hdr(0, 32'h99, 20, 1);
    chk("R5 busy refused", {31'd0, ctl_rdata[1]}, 32'd1);
    drain();
    // R2: synchronizer latency
    ctl_write(4'b1001);
    cs_n = 0; m_cslow = 1;
    tick(); tick();
    chk("R2 no commit after two edges", {31'd0, ctl_rdata[2]}, 32'd0);
    tick();
    chk("R2 commit after third edge", {31'd0, ctl_rdata[2]}, 32'd1);
    m_cmt = 1;
    settle(1);
    // R8: gated with CS low refused
    hdr_write(0, 32'h5A, 10);

    // random mix
    for (int it = 0; it < 300; it++) begin
      case ($urandom % 6)
        0: set_cs($urandom % 2);
        1, 2: ctl_write(4'($urandom));
        default: hdr_write($urandom % 4, $urandom, $urandom % 7);
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule